// File: doc/BRIEF.md
# Differential PSK Barker Chip Modulator

This block turns a stream of tagged symbols into baseband I and Q chip streams for a direct-sequence transmitter. Each accepted symbol carries a rate tag. The tag selects one of two modes. In the one-bit mode (differential BPSK, 1 Mbps), one data bit either keeps the carrier phase or turns it by half a turn. In the two-bit mode (differential QPSK, 2 Mbps), a dibit turns the phase by a multiple of a quarter turn. The block holds the absolute carrier quadrant in a single register. That register carries across any change of tag, so the first symbol after a switch is referenced to the last symbol before it.

The upstream framer sets the tag for each symbol. It uses the one-bit mode for the preamble, either mode for the header, and the chosen mode for the payload. The modulator therefore switches rate at those boundaries with no gap and with the phase continuous. Each symbol lasts eleven chips, one chip per clock. Both rails are multiplied by the same 11-chip Barker word. A new symbol is taken only when the chip sequencer is about to start chip index 0, so `sym_ready` is low for the other ten chips. Each chip is a signed value of plus or minus a fixed amplitude, and the value is zero when no chip is valid.

Top module: `dpsk_barker_mod`

## Requirements
- R1: After reset, `chip_valid` is 0, `sym_ready` is 1 and the carrier quadrant is 0. The first symbol, if it causes no phase change, gives I = Q = +AMP times the Barker word.
- R2: A symbol is accepted on a rising clock edge where `sym_valid` and `sym_ready` are both 1. On the next 11 cycles `chip_valid` is 1 and chips 0 to 10 of that symbol appear in order.
- R3: `sym_ready` is 1 only while idle or during chip index 10. A symbol offered during chip 10 has its chip 0 in the very next cycle, with no gap.
- R4: A `sym_valid` asserted while `sym_ready` is 0 is ignored. No extra symbol is emitted, and the phase used by later symbols does not change.
- R5: Chip k of every symbol is the rail polarity times Barker chip k. The Barker word, chip 0 first, is +1 -1 +1 +1 -1 +1 +1 +1 -1 -1 -1.
- R6: With `sym_rate` = 0 (one-bit mode), `sym_bits[0]` = 0 leaves the phase unchanged and `sym_bits[0]` = 1 turns it by 180 degrees, inverting both rails. `sym_bits[1]` has no effect in this mode.
- R7: With `sym_rate` = 1 (two-bit mode), the dibit is formed from first bit `sym_bits[1]` and second bit `sym_bits[0]`. The phase change is 0 for 00, +90 degrees for 01, 180 degrees for 11 and -90 degrees for 10.
- R8: The rail polarity (I, Q) is set by the quadrant: quadrant 0 gives (+,+), 1 gives (-,+), 2 gives (-,-) and 3 gives (+,-). Starting from quadrant 0, the one-bit mode keeps I equal to Q.
- R9: The rate tag is sampled per symbol. The quadrant is kept across every change of tag in either direction.
- R10: While `chip_valid` is 1, each rail is exactly +AMP or -AMP. While it is 0, both rails are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock, one chip per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | A symbol is offered |
| sym_rate | input | 1 | Rate tag: 0 = one bit per symbol, 1 = dibit per symbol |
| sym_bits | input | 2 | Symbol bits; [1] is the first dibit bit, [0] is the second bit or the only bit |
| sym_ready | output | 1 | The symbol offered this cycle is taken at the edge |
| chip_valid | output | 1 | A chip is present on the rails |
| chip_i | output | OUT_W | Signed in-phase chip |
| chip_q | output | OUT_W | Signed quadrature chip |

## Verification
A wrong quadrant register shows up as a polarity error on one or both rails from chip 0 of the next symbol onward. Because the encoding is differential, the error then persists on every later symbol, so a single mis-stepped dibit is caught within eleven cycles. A wrong chip counter shows up within one symbol: the Barker chips come out of order, or `sym_ready` rises on the wrong chip, which either opens a gap between symbols or lets a symbol in early. A symbol wrongly accepted while the block is busy shows up as extra valid chips where the bench expects the rails to be idle.

// File: rtl/dpsk_mod_pkg.sv
package dpsk_mod_pkg;

   typedef enum logic {
      RATE_ONE_BIT = 1'b0,
      RATE_DIBIT   = 1'b1
   } rate_e;

   // Carrier quadrant: 0,1,2,3 stand for 45,135,225,315 degrees.
   typedef logic [1:0] quad_t;

   // Quadrant advance for one symbol.
   function automatic quad_t quad_step(rate_e r, logic [1:0] bits);
      if (r == RATE_ONE_BIT)
         return {bits[0], 1'b0};
      else
         return {bits[1], bits[1] ^ bits[0]};
   endfunction

   // Rail sign bits for a quadrant, 1 = negative: [1] is I, [0] is Q.
   function automatic logic [1:0] quad_neg(quad_t q);
      return {q[1] ^ q[0], q[1]};
   endfunction

endpackage

// File: rtl/barker_chip_seq.sv
module barker_chip_seq #(
   parameter int CHIPS = 11
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       take,
   output logic                       busy,
   output logic [$clog2(CHIPS)-1:0]   idx,
   output logic                       ready
);
   localparam int IDX_W = $clog2(CHIPS);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(CHIPS - 1);

   if (CHIPS < 2) begin : g_bad_chips
      $error("barker_chip_seq: CHIPS must be at least 2");
   end

   assign ready = !busy || (idx == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (take) begin
         busy <= 1'b1;
         idx  <= '0;
      end else if (busy) begin
         if (idx == LAST) begin
            busy <= 1'b0;
            idx  <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

   assert_start_at_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (busy && idx == '0));

   assert_chip_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1));

   assert_idle_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx == LAST && !take) |=> !busy);

   assert_no_take_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx != LAST) |-> !take);

endmodule

// File: rtl/dpsk_phase_acc.sv
module dpsk_phase_acc
   import dpsk_mod_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take,
   input  rate_e      rate,
   input  logic [1:0] bits,
   output quad_t      quad
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         quad <= '0;
      else if (take)
         quad <= quad + quad_step(rate, bits);
   end

   assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(quad));

   assert_one_bit_half_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (take && rate == RATE_ONE_BIT) |=> (quad[0] == $past(quad[0])));

   assert_dibit_zero_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take && rate == RATE_DIBIT && bits == 2'b00) |=> $stable(quad));

endmodule

// File: rtl/chip_rail_map.sv
module chip_rail_map #(
   parameter int RAILS = 2,
   parameter int OUT_W = 8,
   parameter int AMP   = 64
) (
   input  logic                        en,
   input  logic [RAILS-1:0]            neg,
   output logic [RAILS-1:0][OUT_W-1:0] val
);
   localparam logic [OUT_W-1:0] POS_V = OUT_W'(AMP);
   localparam logic [OUT_W-1:0] NEG_V = OUT_W'(-AMP);

   if (AMP < 1 || AMP >= (1 << (OUT_W - 1))) begin : g_bad_amp
      $error("chip_rail_map: AMP must fit as a positive signed OUT_W value");
   end

   for (genvar g = 0; g < RAILS; g++) begin : g_rail
      assign val[g] = !en ? '0 : (neg[g] ? NEG_V : POS_V);
   end

endmodule

// File: rtl/dpsk_barker_mod.sv
module dpsk_barker_mod
   import dpsk_mod_pkg::*;
#(
   parameter int               CHIPS      = 11,
   parameter logic [CHIPS-1:0] BARKER_NEG = 11'b11100010010,
   parameter int               OUT_W      = 8,
   parameter int               AMP        = 64
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sym_valid,
   input  logic                    sym_rate,
   input  logic [1:0]              sym_bits,
   output logic                    sym_ready,
   output logic                    chip_valid,
   output logic signed [OUT_W-1:0] chip_i,
   output logic signed [OUT_W-1:0] chip_q
);
   localparam int IDX_W = $clog2(CHIPS);
   localparam int RAILS = 2;

   logic                        take;
   logic [IDX_W-1:0]            chip_idx;
   quad_t                       quad;
   logic                        pn_neg;
   logic [RAILS-1:0]            rail_neg;
   logic [RAILS-1:0][OUT_W-1:0] rail_val;

   assign take = sym_valid && sym_ready;

   barker_chip_seq #(.CHIPS(CHIPS)) u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .busy  (chip_valid),
      .idx   (chip_idx),
      .ready (sym_ready)
   );

   dpsk_phase_acc u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .rate  (rate_e'(sym_rate)),
      .bits  (sym_bits),
      .quad  (quad)
   );

   // Both rails share one spreading word; rail 1 is I, rail 0 is Q.
   assign pn_neg   = BARKER_NEG[chip_idx];
   assign rail_neg = quad_neg(quad) ^ {RAILS{pn_neg}};

   chip_rail_map #(.RAILS(RAILS), .OUT_W(OUT_W), .AMP(AMP)) u_map (
      .en  (chip_valid),
      .neg (rail_neg),
      .val (rail_val)
   );

   assign chip_i = rail_val[1];
   assign chip_q = rail_val[0];

   assert_rail_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
      chip_valid |-> ((chip_i == OUT_W'(AMP) || chip_i == OUT_W'(-AMP)) &&
                      (chip_q == OUT_W'(AMP) || chip_q == OUT_W'(-AMP))));

   assert_rail_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_valid |-> (chip_i == '0 && chip_q == '0));

   assert_symbol_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_valid && chip_idx != '0) |-> $stable(quad));

   assert_shared_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_valid && $past(chip_valid) && chip_idx != '0) |->
         ((chip_i == chip_q) == ($past(chip_i) == $past(chip_q))));

endmodule

// File: tb/sim_dpsk_barker_mod.sv
`timescale 1ns/1ps
module sim_dpsk_barker_mod;
   localparam int OUT_W = 8;
   localparam int AMP   = 64;
   localparam int CHIPS = 11;

   logic clk = 1'b0;
   logic rst_n;
   logic sym_valid;
   logic sym_rate;
   logic [1:0] sym_bits;
   logic sym_ready;
   logic chip_valid;
   logic signed [OUT_W-1:0] chip_i;
   logic signed [OUT_W-1:0] chip_q;

   int checks = 0;
   int errors = 0;
   int q_model = 0;
   int bk [CHIPS] = '{1, -1, 1, 1, -1, 1, 1, 1, -1, -1, -1};

   always #2.5 clk = ~clk;

   dpsk_barker_mod #(.OUT_W(OUT_W), .AMP(AMP)) u0 (
      .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_rate(sym_rate),
      .sym_bits(sym_bits), .sym_ready(sym_ready), .chip_valid(chip_valid),
      .chip_i(chip_i), .chip_q(chip_q)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int i_sign(int q);
      case (q)
         0: return 1;
         1: return -1;
         2: return -1;
         default: return 1;
      endcase
   endfunction

   function automatic int q_sign(int q);
      return (q < 2) ? 1 : -1;
   endfunction

   function automatic int step_of(int rate, int b1, int b0);
      if (rate == 0) return b0 ? 2 : 0;
      case ({b1[0], b0[0]})
         2'b00: return 0;
         2'b01: return 1;
         2'b11: return 2;
         default: return 3;
      endcase
   endfunction

   // Called at a falling edge with sym_ready expected high.
   task automatic send(input int rate, input int b1, input int b0,
                       input string tag, input bit poke);
      int ei;
      int eq;
      chk(sym_ready == 1'b1, "R3 ready before symbol", sym_ready, 1);
      sym_valid = 1'b1;
      sym_rate  = rate[0];
      sym_bits  = {b1[0], b0[0]};
      @(posedge clk);
      #1;
      sym_valid = 1'b0;
      sym_bits  = 2'b11;
      q_model   = (q_model + step_of(rate, b1, b0)) % 4;
      for (int k = 0; k < CHIPS; k++) begin
         @(negedge clk);
         if (poke && k < 9) begin
            sym_valid = 1'b1;
            sym_rate  = ~rate[0];
            sym_bits  = k[1:0];
         end
         if (k == 9) sym_valid = 1'b0;
         ei = i_sign(q_model) * bk[k] * AMP;
         eq = q_sign(q_model) * bk[k] * AMP;
         chk(chip_valid == 1'b1, "R2 chip_valid", chip_valid, 1);
         chk(chip_i == ei, {tag, " R5 R8 chip_i"}, chip_i, ei);
         chk(chip_q == eq, {tag, " R5 R8 chip_q"}, chip_q, eq);
         chk(sym_ready == (k == CHIPS - 1), "R3 ready timing", sym_ready, int'(k == CHIPS - 1));
      end
   endtask

   task automatic idle(input int n, input string tag);
      for (int j = 0; j < n; j++) begin
         @(negedge clk);
         chk(chip_valid == 1'b0, {tag, " R10 idle valid"}, chip_valid, 0);
         chk(chip_i == 0 && chip_q == 0, {tag, " R10 idle rails"}, chip_i, 0);
         chk(sym_ready == 1'b1, {tag, " R3 idle ready"}, sym_ready, 1);
      end
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      sym_valid = 1'b0;
      sym_rate  = 1'b0;
      sym_bits  = 2'b00;
      repeat (3) @(negedge clk);
      chk(chip_valid == 1'b0, "R1 reset valid", chip_valid, 0);
      chk(sym_ready == 1'b1, "R1 reset ready", sym_ready, 1);
      chk(chip_i == 0 && chip_q == 0, "R1 reset rails", chip_i, 0);
      rst_n = 1'b1;
      idle(2, "R1");

      // One-bit mode from reset: rails tied, bit 1 of the input is ignored.
      send(0, 0, 0, "R1 R6", 1'b0);
      send(0, 1, 1, "R6", 1'b0);
      send(0, 1, 0, "R6 ignored bit", 1'b0);
      send(0, 0, 1, "R6", 1'b0);
      send(0, 0, 0, "R6", 1'b0);
      idle(2, "R2");

      // Dibit mode: every dibit from every start quadrant, gapless.
      for (int a = 0; a < 4; a++) begin
         for (int d = 0; d < 4; d++) begin
            send(1, (d >> 1) & 1, d & 1, (a == 0 && d == 0) ? "R9 R7" : "R7", 1'b0);
         end
         send(1, 0, 1, "R7", 1'b0);
      end

      // Switch back to the one-bit mode at an odd quadrant.
      send(1, 0, 1, "R7", 1'b0);
      send(0, 0, 1, "R9 R6", 1'b0);
      send(0, 0, 0, "R9 R6", 1'b0);
      send(1, 1, 1, "R9 R7", 1'b0);

      // Offer symbols while busy; they must be dropped.
      send(1, 1, 0, "R4", 1'b1);
      idle(3, "R4");
      send(0, 0, 0, "R4 phase kept", 1'b0);
      idle(2, "R10");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule